// File: doc/BRIEF.md
# Four-Channel Transfer Controller Programming Port

This block is the byte-wide register file of a four-channel transfer controller. A host reaches it through a 4-bit register offset taken from the I/O address. A parameter shifts the address right by one first, for a controller whose registers sit on word-spaced addresses. Offsets 0 to 7 give each channel a 16-bit start address and a 16-bit transfer length. Offsets 8 to 15 hold the controller-wide command, request, mask, mode and reset functions.

The 16-bit channel registers are reached one byte at a time. A single shared byte-pointer bit selects the low or the high byte and flips on every channel access. Writing the high byte of either register restarts the channel: its working address is reloaded and its progress counter is cleared.

A transfer engine outside this block does two things through its own inputs. It reports how far each channel has progressed, and it flags channels that reached terminal count. The request scheduler reads the mask, the status and the command from the outputs.

Top module: `dma_prog_if`

## Requirements
- R1: The register offset is `addr >> ADDR_SHIFT` truncated to 4 bits. Offsets 0..7 select a channel register: channel = offset[2:1], and offset[0] picks the start address (0) or the length (1).
- R2: The byte pointer flips on every read or write of offsets 0..7 and on no other cycle. When it is 0 the low byte is accessed, and when it is 1 the high byte.
- R3: A high-byte write to either channel register copies the start address (with this write applied) into the working address and sets the channel's progress count to 0.
- R4: A length read returns start length minus progress. An address read returns working address plus progress, or minus progress when bit 5 of the channel's mode byte is 1.
- R5: A write to offset 8 stores the command only when the value is 0x00 or 0x04. Any other value leaves the command unchanged. The command is visible on `cmd_o`.
- R6: A read of offset 8 returns the 8-bit status and then clears status[3:0]. A 1 on `tc_set[i]` sets status[i] at the next edge, and this set takes effect over the read clear.
- R7: A write to offset 9 with data[1:0]=c sets status[c+4] to data[2] and clears status[c].
- R8: Offset 10 writes mask[data[1:0]] = data[2]. Offset 14 clears all four mask bits. Offset 15 writes mask = data[3:0] and reads back {4'b0, mask}. The mask is visible on `mask_o`.
- R9: Offset 11 stores the whole data byte as the mode byte of channel data[1:0].
- R10: Offset 12 clears the byte pointer. Offset 13, and the hardware reset, set the byte pointer to 0, mask to 4'hF, status to 0 and command to 0, and this also takes effect over `tc_set`.
- R11: Reads of offsets 9 through 14 return 0x00, and the byte pointer keeps its value.
- R12: `prog_we` loads `prog_val` into the progress count of channel `prog_chan`. A high-byte register write to the same channel in the same cycle takes effect over this load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access (ignored when wr_en is also high) |
| addr | input | 4+ADDR_SHIFT | I/O address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid during the rd_en cycle |
| prog_we | input | 1 | Progress count load from the transfer engine |
| prog_chan | input | 2 | Channel for the progress load |
| prog_val | input | 16 | Progress count value |
| tc_set | input | 4 | Terminal-count flags, one per channel |
| mask_o | output | 4 | Channel mask bits |
| status_o | output | 8 | Request bits [7:4], terminal-count bits [3:0] |
| cmd_o | output | 8 | Command register |

## Verification
Read data comes from the register state without a register stage. The bench therefore samples `rdata` in the same cycle as `rd_en`, one nanosecond after driving it at the falling edge and before the rising edge. All other results (byte pointer, mask, status, command, channel values) are registered. They become visible one cycle after the strobe, so each operation's effect is compared at the falling-edge sample of the following cycle. The bench model is updated only at the rising edge, so both kinds of sample compare against the state the design holds at that moment.

// File: rtl/dma_prog_pkg.sv
package dma_prog_pkg;
    localparam int NCH  = 4;
    localparam int CH_W = $clog2(NCH);
    localparam int RW   = 16;

    typedef enum logic [3:0] {
        OFF_CMD     = 4'h8,
        OFF_REQ     = 4'h9,
        OFF_SMASK   = 4'hA,
        OFF_MODE    = 4'hB,
        OFF_CLRFF   = 4'hC,
        OFF_MRST    = 4'hD,
        OFF_CLRMASK = 4'hE,
        OFF_ALLMASK = 4'hF
    } ctl_off_e;

    // Bits that may be set in an accepted command value
    localparam logic [7:0] CMD_OK_BITS = 8'h04;

    typedef struct packed {
        logic              ff;
        logic [7:0]        cmd;
        logic [NCH-1:0]    mask;
        logic [2*NCH-1:0]  status;
    } ctl_t;

    localparam ctl_t CTL_RST = '{ff: 1'b0, cmd: 8'h00, mask: '1, status: '0};

    typedef struct packed {
        logic [RW-1:0] base_addr;
        logic [RW-1:0] base_len;
        logic [RW-1:0] cur_addr;
        logic [RW-1:0] prog;
        logic [7:0]    mode;
    } chan_t;
endpackage

// File: rtl/dma_prog_decode.sv
module dma_prog_decode #(
    parameter int SHIFT = 0,
    parameter int AW    = 4 + SHIFT
) (
    input  logic [AW-1:0] addr,
    output logic [3:0]    off,
    output logic          is_chan,
    output logic [1:0]    chan,
    output logic          is_len
);
    logic [AW-1:0] shifted;

    always_comb begin
        shifted = addr >> SHIFT;
        off     = shifted[3:0];
        is_chan = ~off[3];
        chan    = off[2:1];
        is_len  = off[0];
    end
endmodule

// File: rtl/dma_prog_chan.sv
module dma_prog_chan
    import dma_prog_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_sel,
    input  logic          is_len,
    input  logic          hi,
    input  logic [7:0]    wdata,
    input  logic          mode_we,
    input  logic          prog_we,
    input  logic [RW-1:0] prog_val,
    output logic [RW-1:0] addr_rd,
    output logic [RW-1:0] len_rd,
    output logic [7:0]    mode
);
    chan_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (prog_we) ch_d.prog = prog_val;
        if (wr_sel) begin
            if (is_len) begin
                if (hi) ch_d.base_len[15:8] = wdata;
                else    ch_d.base_len[7:0]  = wdata;
            end else begin
                if (hi) ch_d.base_addr[15:8] = wdata;
                else    ch_d.base_addr[7:0]  = wdata;
            end
            if (hi) begin
                ch_d.cur_addr = ch_d.base_addr;
                ch_d.prog     = '0;
            end
        end
        if (mode_we) ch_d.mode = wdata;

        addr_rd = ch_q.mode[5] ? (ch_q.cur_addr - ch_q.prog) : (ch_q.cur_addr + ch_q.prog);
        len_rd  = ch_q.base_len - ch_q.prog;
        mode    = ch_q.mode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    // R3: high-byte write restarts the channel
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && hi) |=> (ch_q.prog == '0 && addr_rd == ch_q.base_addr));

    // R12: progress load lands when no restart competes
    p_prog_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_we && !wr_sel) |=> (len_rd == ch_q.base_len - $past(prog_val)));
endmodule

// File: rtl/dma_prog_if.sv
module dma_prog_if
    import dma_prog_pkg::*;
#(
    parameter int ADDR_SHIFT = 0,
    parameter int AW         = 4 + ADDR_SHIFT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [AW-1:0]   addr,
    input  logic [7:0]      wdata,
    output logic [7:0]      rdata,
    input  logic            prog_we,
    input  logic [CH_W-1:0] prog_chan,
    input  logic [RW-1:0]   prog_val,
    input  logic [NCH-1:0]  tc_set,
    output logic [NCH-1:0]  mask_o,
    output logic [7:0]      status_o,
    output logic [7:0]      cmd_o
);
    logic [3:0] off;
    logic       is_chan;
    logic [1:0] chan;
    logic       is_len;

    dma_prog_decode #(.SHIFT(ADDR_SHIFT), .AW(AW)) u_dec (
        .addr    (addr),
        .off     (off),
        .is_chan (is_chan),
        .chan    (chan),
        .is_len  (is_len)
    );

    ctl_t ctl_d, ctl_q;

    logic [RW-1:0] addr_rd [NCH];
    logic [RW-1:0] len_rd  [NCH];
    logic [7:0]    mode_v  [NCH];

    logic wr, rd;
    assign wr = wr_en;
    assign rd = rd_en & ~wr_en;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic sel_w, mode_w, prog_w;
        assign sel_w  = wr && is_chan && (chan == CH_W'(g));
        assign mode_w = wr && (off == OFF_MODE) && (wdata[1:0] == CH_W'(g));
        assign prog_w = prog_we && (prog_chan == CH_W'(g));

        dma_prog_chan u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (sel_w),
            .is_len   (is_len),
            .hi       (ctl_q.ff),
            .wdata    (wdata),
            .mode_we  (mode_w),
            .prog_we  (prog_w),
            .prog_val (prog_val),
            .addr_rd  (addr_rd[g]),
            .len_rd   (len_rd[g]),
            .mode     (mode_v[g])
        );
    end

    logic [RW-1:0] chan_val;

    always_comb begin
        ctl_d = ctl_q;
        if ((wr_en || rd_en) && is_chan) ctl_d.ff = ~ctl_q.ff;
        if (wr) begin
            case (off)
                OFF_CMD:     if ((wdata & ~CMD_OK_BITS) == 8'h00) ctl_d.cmd = wdata;
                OFF_REQ: begin
                    ctl_d.status[{1'b1, wdata[1:0]}] = wdata[2];
                    ctl_d.status[{1'b0, wdata[1:0]}] = 1'b0;
                end
                OFF_SMASK:   ctl_d.mask[wdata[1:0]] = wdata[2];
                OFF_CLRFF:   ctl_d.ff = 1'b0;
                OFF_MRST:    ctl_d = CTL_RST;
                OFF_CLRMASK: ctl_d.mask = '0;
                OFF_ALLMASK: ctl_d.mask = wdata[NCH-1:0];
                default: ;
            endcase
        end else if (rd && off == OFF_CMD) begin
            ctl_d.status[NCH-1:0] = '0;
        end
        if (!(wr && off == OFF_MRST)) ctl_d.status[NCH-1:0] = ctl_d.status[NCH-1:0] | tc_set;

        chan_val = is_len ? len_rd[chan] : addr_rd[chan];
        rdata    = 8'h00;
        if (rd_en) begin
            if (is_chan)                rdata = ctl_q.ff ? chan_val[15:8] : chan_val[7:0];
            else if (off == OFF_CMD)    rdata = ctl_q.status;
            else if (off == OFF_ALLMASK) rdata = 8'(ctl_q.mask);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    assign mask_o   = ctl_q.mask;
    assign status_o = ctl_q.status;
    assign cmd_o    = ctl_q.cmd;

    // Mode bits other than the direction bit are stored for the scheduler only
    logic mode_unused;
    always_comb begin
        mode_unused = 1'b0;
        for (int i = 0; i < NCH; i++) mode_unused = mode_unused ^ (^mode_v[i]);
    end

    p_ff_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en || rd_en) |=> $stable(ctl_q.ff));

    p_ff_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && is_chan) |=> (ctl_q.ff != $past(ctl_q.ff)));

    p_cmd_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_CMD && (wdata & ~CMD_OK_BITS) != 8'h00) |=> $stable(cmd_o));

    p_stat_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && off == OFF_CMD && tc_set == '0) |=> (status_o[NCH-1:0] == '0));

    p_mreset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_MRST) |=> (mask_o == '1 && status_o == '0 && cmd_o == 8'h00 && !ctl_q.ff));

    p_rd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !is_chan && off != OFF_CMD && off != OFF_ALLMASK) |-> (rdata == 8'h00));
endmodule

// File: tb/tb_dma_prog_if.sv
`timescale 1ns/1ps
module tb_dma_prog_if;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, rd_en;
    logic [3:0]  addr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic        prog_we;
    logic [1:0]  prog_chan;
    logic [15:0] prog_val;
    logic [3:0]  tc_set;
    logic [3:0]  mask_o;
    logic [7:0]  status_o;
    logic [7:0]  cmd_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    dma_prog_if dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .prog_we(prog_we), .prog_chan(prog_chan),
        .prog_val(prog_val), .tc_set(tc_set), .mask_o(mask_o),
        .status_o(status_o), .cmd_o(cmd_o)
    );

    // Bench model of the register state
    logic [15:0] m_ba [4];
    logic [15:0] m_bl [4];
    logic [15:0] m_cur[4];
    logic [15:0] m_pg [4];
    logic [7:0]  m_mode[4];
    logic        m_ff;
    logic [7:0]  m_cmd;
    logic [3:0]  m_mask;
    logic [7:0]  m_st;

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [3:0] off);
        logic [1:0]  c = off[2:1];
        logic [15:0] v;
        if (!off[3]) begin
            if (off[0]) v = m_bl[c] - m_pg[c];
            else        v = m_mode[c][5] ? m_cur[c] - m_pg[c] : m_cur[c] + m_pg[c];
            return m_ff ? v[15:8] : v[7:0];
        end
        if (off == 4'h8) return m_st;
        if (off == 4'hF) return {4'b0, m_mask};
        return 8'h00;
    endfunction

    function automatic string tag_of(input logic [3:0] off);
        if (!off[3])       return "R4 channel read";
        if (off == 4'h8)   return "R6 status read";
        if (off == 4'hF)   return "R8 mask read";
        return "R11 zero read";
    endfunction

    task automatic model_step(input bit wr, input bit rd, input logic [3:0] off, input logic [7:0] d,
                              input bit pw, input logic [1:0] pc, input logic [15:0] pv,
                              input logic [3:0] tc);
        logic [1:0] c = off[2:1];
        logic       old_ff = m_ff;
        if (pw) m_pg[pc] = pv;
        if ((wr || rd) && !off[3]) m_ff = !m_ff;
        if (wr) begin
            if (!off[3]) begin
                if (off[0]) begin
                    if (old_ff) m_bl[c][15:8] = d; else m_bl[c][7:0] = d;
                end else begin
                    if (old_ff) m_ba[c][15:8] = d; else m_ba[c][7:0] = d;
                end
                if (old_ff) begin m_cur[c] = m_ba[c]; m_pg[c] = 16'h0; end
            end else begin
                case (off)
                    4'h8: if ((d & 8'hFB) == 8'h00) m_cmd = d;
                    4'h9: begin m_st[{1'b1, d[1:0]}] = d[2]; m_st[{1'b0, d[1:0]}] = 1'b0; end
                    4'hA: m_mask[d[1:0]] = d[2];
                    4'hB: m_mode[d[1:0]] = d;
                    4'hC: m_ff = 1'b0;
                    4'hD: begin m_ff = 1'b0; m_mask = 4'hF; m_st = 8'h00; m_cmd = 8'h00; end
                    4'hE: m_mask = 4'h0;
                    default: m_mask = d[3:0];
                endcase
            end
        end else if (rd && off == 4'h8) begin
            m_st[3:0] = 4'h0;
        end
        if (!(wr && off == 4'hD)) m_st[3:0] = m_st[3:0] | tc;
    endtask

    task automatic check_outs();
        chk({12'h0, mask_o}, {12'h0, m_mask}, "R8 mask_o");
        chk({8'h0, status_o}, {8'h0, m_st}, "R6/R7 status_o");
        chk({8'h0, cmd_o}, {8'h0, m_cmd}, "R5 cmd_o");
    endtask

    task automatic op(input bit wr, input bit rd, input logic [3:0] off, input logic [7:0] d,
                      input bit pw, input logic [1:0] pc, input logic [15:0] pv,
                      input logic [3:0] tc, input string tag);
        @(negedge clk);
        wr_en = wr; rd_en = rd; addr = off; wdata = d;
        prog_we = pw; prog_chan = pc; prog_val = pv; tc_set = tc;
        #1;
        if (rd) chk({8'h0, rdata}, {8'h0, exp_rd(off)}, (tag == "") ? tag_of(off) : tag);
        check_outs();
        @(posedge clk);
        model_step(wr, rd, off, d, pw, pc, pv, tc);
        #1;
        wr_en = 0; rd_en = 0; prog_we = 0; tc_set = 4'h0;
    endtask

    task automatic wr_reg(input logic [3:0] off, input logic [7:0] d);
        op(1, 0, off, d, 0, 2'd0, 16'h0, 4'h0, "");
    endtask

    task automatic rd_reg(input logic [3:0] off, input string tag);
        op(0, 1, off, 8'h00, 0, 2'd0, 16'h0, 4'h0, tag);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) begin
            m_ba[i] = 0; m_bl[i] = 0; m_cur[i] = 0; m_pg[i] = 0; m_mode[i] = 0;
        end
        m_ff = 0; m_cmd = 0; m_mask = 4'hF; m_st = 0;
        rst_n = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
        prog_we = 0; prog_chan = 0; prog_val = 0; tc_set = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R10: hardware reset state
        @(negedge clk); #1;
        check_outs();

        // R1, R2, R3: channel 1 address via offset 2, length via offset 3
        wr_reg(4'h2, 8'h34);
        wr_reg(4'h2, 8'h12);
        wr_reg(4'h3, 8'h10);
        wr_reg(4'h3, 8'h00);
        // R12: progress 5 on channel 1
        op(0, 0, 4'h0, 8'h0, 1, 2'd1, 16'd5, 4'h0, "");
        wr_reg(4'hB, 8'h41);                      // R9 mode, increment
        rd_reg(4'h2, "R4 addr low up");           // 0x39
        rd_reg(4'h2, "R4 addr high up");          // 0x12
        rd_reg(4'h3, "R4 len low");               // 0x0B
        rd_reg(4'h3, "R4 len high");
        wr_reg(4'hB, 8'h61);                      // R9 decrement bit 5
        rd_reg(4'h2, "R9 addr low down");         // 0x2F
        rd_reg(4'h2, "R9 addr high down");
        // R3: restart clears progress
        wr_reg(4'h3, 8'h20);
        wr_reg(4'h3, 8'h00);
        rd_reg(4'h2, "R3 addr low after restart");
        // R2: clear pointer then low byte
        rd_reg(4'h0, "R2 toggling read");
        wr_reg(4'hC, 8'h00);
        rd_reg(4'h3, "R2 low after clear");
        wr_reg(4'hC, 8'h00);
        // R5: command accept and reject
        wr_reg(4'h8, 8'h04);
        wr_reg(4'h8, 8'h01);
        wr_reg(4'h8, 8'h80);
        wr_reg(4'h8, 8'h00);
        // R7: software request
        wr_reg(4'h9, 8'h06);
        wr_reg(4'h9, 8'h02);
        // R6: terminal count and read clear, set wins
        op(0, 0, 4'h0, 8'h0, 0, 2'd0, 16'h0, 4'h5, "");
        op(0, 1, 4'h8, 8'h0, 0, 2'd0, 16'h0, 4'h2, "R6 status read with set");
        rd_reg(4'h8, "R6 status read");
        // R8: masks
        wr_reg(4'hE, 8'h00);
        wr_reg(4'hA, 8'h05);
        wr_reg(4'hF, 8'hFA);
        rd_reg(4'hF, "R8 mask readback");
        // R11: zero reads, pointer unchanged
        for (int o = 9; o <= 14; o++) rd_reg(4'(o), "R11 zero read");
        rd_reg(4'h3, "R11 pointer kept");
        // R10: master reset over terminal count
        wr_reg(4'h9, 8'h07);
        op(1, 0, 4'hD, 8'h00, 0, 2'd0, 16'h0, 4'hF, "");
        rd_reg(4'h1, "R10 pointer cleared");
        // R12: same-cycle restart wins over progress load
        wr_reg(4'hC, 8'h00);
        wr_reg(4'h4, 8'h77);
        op(1, 0, 4'h4, 8'h01, 1, 2'd2, 16'h0033, 4'h0, "");
        rd_reg(4'h4, "R12 restart over load");

        // Constrained random mix
        for (int n = 0; n < 2000; n++) begin
            int k = int'($urandom_range(0, 9));
            if (k == 0)
                op(0, 0, 4'h0, 8'h0, 1, 2'($urandom), 16'($urandom), 4'h0, "");
            else if (k == 1)
                op(0, 0, 4'h0, 8'h0, 0, 2'd0, 16'h0, 4'($urandom), "");
            else begin
                logic [7:0] d = 8'($urandom);
                if (($urandom & 3) == 0) d = d & 8'h04;
                op(k[0], !k[0], 4'($urandom), d, 0, 2'd0, 16'h0, 4'h0, "");
            end
        end

        @(negedge clk); #1;
        check_outs();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule